// File: doc/BRIEF.md
# Hardwired Timing and Control Unit

This block is the hardwired sequencer and control decoder for a 16-bit accumulator machine with a 12-bit address space. A 4-bit step counter advances once per clock. A decoder turns the count into one-hot timing slots, and a second decoder turns the three opcode bits of the instruction word into one-hot operation lines. Every control strobe is a product of one slot, one operation line and, where needed, a status input. The strobes go to an external datapath that holds the address, program counter, data, accumulator, instruction and temporary registers, the memory and the ALU.

The step counter returns to zero as soon as the last micro-operation of an instruction has been issued. Instructions therefore take between four and seven cycles. A run flag is set by reset and cleared by the halt instruction. While it is clear, every strobe is held low and the counter stops. The indirect flag is read from bit 15 of the instruction word, and the opcode from bits 14 to 12. When the interrupt flag is high at slot 0, a three-cycle interrupt sequence runs in place of the fetch.

Top module: `hc_control_unit`

## Requirements
- R1: Reset puts the counter in slot 0 with the run flag set, so the first cycle after reset drives the fetch slot-0 strobes.
- R2: The fetch runs as follows, with the interrupt flag low. Slot 0 loads the address register from the program counter (bus code 2). Slot 1 reads memory (bus code 7), loads the instruction register and increments the program counter. Slot 2 loads the address register from the instruction register (bus code 5).
- R3: At slot 3, opcodes 0 to 6 with bit 15 set read memory and load the address register. With bit 15 clear they issue no strobe.
- R4: Opcodes 0, 1 and 2 read memory into the data register at slot 4 and load the accumulator at slot 5. The next cycle is slot 0.
- R5: Opcode 3 writes memory from the accumulator (bus code 4) at slot 4. Opcode 4 loads the program counter from the address register (bus code 1) at slot 4. Both then return to slot 0.
- R6: Opcode 5 writes memory from the program counter (bus code 2) and increments the address register at slot 4. At slot 5 it loads the program counter from the address register (bus code 1).
- R7: Opcode 6 reads into the data register at slot 4 and increments the data register at slot 5. At slot 6 it writes memory from the data register (bus code 3) and increments the program counter only when the data-zero input is high.
- R8: Opcode 7 with bit 15 clear executes at slot 3 from one-hot bits 11 down to 0 of the instruction word, then returns to slot 0. The bits act as follows:
  - bit 11 clears the accumulator;
  - bits 9, 7 and 6 load the accumulator;
  - bit 5 increments the accumulator;
  - bits 10 and 8 issue no strobe here;
  - bits 4, 3, 2 and 1 increment the program counter when, in turn, the sign is clear, the sign is set, the accumulator is zero, or E is clear.
- R9: Opcode 7 with bit 15 clear and bit 0 set clears the run flag. From the next cycle on, all strobes and the bus code stay zero until reset.
- R10: Opcode 7 with bit 15 set executes at slot 3 and returns to slot 0. The bits act as follows:
  - bit 11 loads the accumulator;
  - bit 10 places the accumulator on the bus (code 4);
  - bit 9 increments the program counter when the input flag is set;
  - bit 8 increments the program counter when the output flag is set;
  - bits 7 and 6 issue no strobe.
- R11: With the interrupt flag high at slot 0, the following replaces the fetch. Slot 0 clears the address register and loads the temporary register from the program counter (bus code 2). Slot 1 writes memory from the temporary register (bus code 6) and clears the program counter. Slot 2 increments the program counter and returns to slot 0.
- R12: The bus code is the OR of the codes of the active source terms. A memory read always selects code 7, and a memory read and a memory write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irWord | input | 16 | Instruction register contents |
| eFlag | input | 1 | Carry/extension flag E |
| rFlag | input | 1 | Interrupt-pending flag |
| acZero | input | 1 | Accumulator equals zero |
| acSign | input | 1 | Accumulator bit 15 |
| drZero | input | 1 | Data register equals zero |
| fgi | input | 1 | Input-ready flag |
| fgo | input | 1 | Output-ready flag |
| arLd | output | 1 | Address register load |
| arInr | output | 1 | Address register increment |
| arClr | output | 1 | Address register clear |
| pcLd | output | 1 | Program counter load |
| pcInr | output | 1 | Program counter increment |
| pcClr | output | 1 | Program counter clear |
| drLd | output | 1 | Data register load |
| drInr | output | 1 | Data register increment |
| acLd | output | 1 | Accumulator load from ALU |
| acInr | output | 1 | Accumulator increment |
| acClr | output | 1 | Accumulator clear |
| irLd | output | 1 | Instruction register load |
| trLd | output | 1 | Temporary register load |
| memRd | output | 1 | Memory read |
| memWr | output | 1 | Memory write |
| busSel | output | 3 | Common bus source code |
| running | output | 1 | Run flag |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 3-bit opcode and a 4-bit step counter. These defaults make the full slot range up to slot 6 and all eight opcode lines reachable. Each skip condition is driven both true and false, so a skip that fires on the wrong polarity shows up as an extra or missing program-counter increment. The return to slot 0 is checked after every instruction length, from four to seven cycles. The halt case is followed by several idle cycles and a fresh reset.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int BUS_W = 3;
  localparam logic [BUS_W-1:0] BUS_NONE = 3'd0;
  localparam logic [BUS_W-1:0] BUS_AR   = 3'd1;
  localparam logic [BUS_W-1:0] BUS_PC   = 3'd2;
  localparam logic [BUS_W-1:0] BUS_DR   = 3'd3;
  localparam logic [BUS_W-1:0] BUS_AC   = 3'd4;
  localparam logic [BUS_W-1:0] BUS_IR   = 3'd5;
  localparam logic [BUS_W-1:0] BUS_TR   = 3'd6;
  localparam logic [BUS_W-1:0] BUS_MEM  = 3'd7;

  typedef struct packed {
    logic arLd;
    logic arInr;
    logic arClr;
    logic pcLd;
    logic pcInr;
    logic pcClr;
    logic drLd;
    logic drInr;
    logic acLd;
    logic acInr;
    logic acClr;
    logic irLd;
    logic trLd;
    logic memRd;
    logic memWr;
    logic [BUS_W-1:0] busSel;
  } ctrl_t;
endpackage

// File: rtl/hc_sequencer.sv
module hc_sequencer #(
  parameter int SC_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   scClr,
  input  logic                   haltReq,
  output logic [(1<<SC_W)-1:0]   tSlot,
  output logic                   running
);
  localparam int SLOTS = 1 << SC_W;

  logic [SC_W-1:0] scCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scCnt   <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (scClr) scCnt <= '0;
      else       scCnt <= scCnt + 1'b1;
      if (haltReq) running <= 1'b0;
    end
  end

  // timing decoder: one line per count value
  generate
    for (genvar k = 0; k < SLOTS; k++) begin : g_tdec
      assign tSlot[k] = (scCnt == SC_W'(k));
    end
  endgenerate
endmodule

// File: rtl/hc_strobe_logic.sv
module hc_strobe_logic
  import hc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  parameter int USED_SLOTS = 7
) (
  input  logic [USED_SLOTS-1:0] tSlot,
  input  logic                  running,
  input  logic [WORD_W-1:0]     irWord,
  input  logic                  eFlag,
  input  logic                  rFlag,
  input  logic                  acZero,
  input  logic                  acSign,
  input  logic                  drZero,
  input  logic                  fgi,
  input  logic                  fgo,
  output ctrl_t                 ctl,
  output logic                  scClr,
  output logic                  haltReq
);
  localparam int OPS    = 1 << OP_W;
  localparam int ADDR_W = WORD_W - OP_W - 1;
  localparam int SRC_N  = 8;
  // register-reference bit positions
  localparam int B_CLA = 11, B_CMA = 9, B_CIR = 7, B_CIL = 6, B_INC = 5;
  localparam int B_SPA = 4, B_SNA = 3, B_SZA = 2, B_SZE = 1, B_HLT = 0;
  // input-output bit positions
  localparam int B_INP = 11, B_OUT = 10, B_SKI = 9, B_SKO = 8;

  logic [OPS-1:0]    dOp;
  logic [ADDR_W-1:0] rb;
  logic              indBit;

  assign indBit = irWord[WORD_W-1];
  assign rb     = irWord[ADDR_W-1:0];

  generate
    for (genvar k = 0; k < OPS; k++) begin : g_opdec
      assign dOp[k] = (irWord[WORD_W-2 -: OP_W] == OP_W'(k));
    end
  endgenerate

  logic fetch0, fetch1, fetch2, int0, int1, int2;
  logic memRef, rrT, ioT, indT, skipRr, skipIo;
  logic andT5, addT5, ldaT5, readT4, staT4, bunT4, bsaT4, bsaT5, iszT5, iszT6;
  logic [SRC_N-1:1] selTerm;
  ctrl_t raw;
  logic  clrRaw;

  always_comb begin
    fetch0 = !rFlag && tSlot[0];
    fetch1 = !rFlag && tSlot[1];
    fetch2 = !rFlag && tSlot[2];
    int0   = rFlag && tSlot[0];
    int1   = rFlag && tSlot[1];
    int2   = rFlag && tSlot[2];
    memRef = !dOp[OPS-1];
    rrT    = dOp[OPS-1] && !indBit && tSlot[3];
    ioT    = dOp[OPS-1] && indBit && tSlot[3];
    indT   = memRef && indBit && tSlot[3];
    readT4 = (dOp[0] || dOp[1] || dOp[2] || dOp[6]) && tSlot[4];
    andT5  = dOp[0] && tSlot[5];
    addT5  = dOp[1] && tSlot[5];
    ldaT5  = dOp[2] && tSlot[5];
    staT4  = dOp[3] && tSlot[4];
    bunT4  = dOp[4] && tSlot[4];
    bsaT4  = dOp[5] && tSlot[4];
    bsaT5  = dOp[5] && tSlot[5];
    iszT5  = dOp[6] && tSlot[5];
    iszT6  = dOp[6] && tSlot[6];
    skipRr = rrT && ((rb[B_SPA] && !acSign) || (rb[B_SNA] && acSign) ||
                     (rb[B_SZA] && acZero) || (rb[B_SZE] && !eFlag));
    skipIo = ioT && ((rb[B_SKI] && fgi) || (rb[B_SKO] && fgo));

    // bus source terms, indexed by their code
    selTerm[1] = bunT4 || bsaT5;
    selTerm[2] = fetch0 || int0 || bsaT4;
    selTerm[3] = iszT6;
    selTerm[4] = staT4 || (ioT && rb[B_OUT]);
    selTerm[5] = fetch2;
    selTerm[6] = int1;
    selTerm[7] = fetch1 || indT || readT4;

    raw = '0;
    for (int k = 1; k < SRC_N; k++) begin
      if (selTerm[k]) raw.busSel = raw.busSel | BUS_W'(k);
    end
    raw.arLd  = fetch0 || fetch2 || indT;
    raw.arClr = int0;
    raw.arInr = bsaT4;
    raw.pcLd  = bunT4 || bsaT5;
    raw.pcInr = fetch1 || int2 || skipRr || skipIo || (iszT6 && drZero);
    raw.pcClr = int1;
    raw.drLd  = readT4;
    raw.drInr = iszT5;
    raw.acLd  = andT5 || addT5 || ldaT5 ||
                (rrT && (rb[B_CMA] || rb[B_CIR] || rb[B_CIL])) ||
                (ioT && rb[B_INP]);
    raw.acInr = rrT && rb[B_INC];
    raw.acClr = rrT && rb[B_CLA];
    raw.irLd  = fetch1;
    raw.trLd  = int0;
    raw.memRd = selTerm[7];
    raw.memWr = int1 || staT4 || bsaT4 || iszT6;

    clrRaw = int2 || rrT || ioT || andT5 || addT5 || ldaT5 ||
             staT4 || bunT4 || bsaT5 || iszT6;

    ctl     = running ? raw : '0;
    scClr   = running && clrRaw;
    haltReq = running && rrT && rb[B_HLT];
  end
endmodule

// File: rtl/hc_control_unit.sv
module hc_control_unit
  import hc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  parameter int SC_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WORD_W-1:0] irWord,
  input  logic             eFlag,
  input  logic             rFlag,
  input  logic             acZero,
  input  logic             acSign,
  input  logic             drZero,
  input  logic             fgi,
  input  logic             fgo,
  output logic             arLd,
  output logic             arInr,
  output logic             arClr,
  output logic             pcLd,
  output logic             pcInr,
  output logic             pcClr,
  output logic             drLd,
  output logic             drInr,
  output logic             acLd,
  output logic             acInr,
  output logic             acClr,
  output logic             irLd,
  output logic             trLd,
  output logic             memRd,
  output logic             memWr,
  output logic [2:0]       busSel,
  output logic             running
);
  localparam int SLOTS      = 1 << SC_W;
  localparam int USED_SLOTS = 7;

  logic [SLOTS-1:0] tSlot;
  logic             scClr;
  logic             haltReq;
  ctrl_t            ctl;

  hc_sequencer #(.SC_W(SC_W)) u_seq (
    .clk(clk), .rstN(rstN), .scClr(scClr), .haltReq(haltReq),
    .tSlot(tSlot), .running(running)
  );

  hc_strobe_logic #(.WORD_W(WORD_W), .OP_W(OP_W), .USED_SLOTS(USED_SLOTS)) u_logic (
    .tSlot(tSlot[USED_SLOTS-1:0]), .running(running), .irWord(irWord),
    .eFlag(eFlag), .rFlag(rFlag), .acZero(acZero), .acSign(acSign),
    .drZero(drZero), .fgi(fgi), .fgo(fgo),
    .ctl(ctl), .scClr(scClr), .haltReq(haltReq)
  );

  assign arLd   = ctl.arLd;
  assign arInr  = ctl.arInr;
  assign arClr  = ctl.arClr;
  assign pcLd   = ctl.pcLd;
  assign pcInr  = ctl.pcInr;
  assign pcClr  = ctl.pcClr;
  assign drLd   = ctl.drLd;
  assign drInr  = ctl.drInr;
  assign acLd   = ctl.acLd;
  assign acInr  = ctl.acInr;
  assign acClr  = ctl.acClr;
  assign irLd   = ctl.irLd;
  assign trLd   = ctl.trLd;
  assign memRd  = ctl.memRd;
  assign memWr  = ctl.memWr;
  assign busSel = ctl.busSel;
endmodule

// File: rtl/hc_control_checker.sv
module hc_control_checker #(
  parameter int SLOTS = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [SLOTS-1:0] tSlot,
  input logic             running,
  input logic             scClr,
  input logic             rFlag,
  input logic             arClr,
  input logic             trLd,
  input logic             memRd,
  input logic             memWr,
  input logic [2:0]       busSel,
  input logic [14:0]      allStrobes
);
  p_slot_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    running |-> $countones(tSlot) == 1);

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && !scClr && tSlot[1]) |=> tSlot[2]);

  p_clear_to_t0_r4: assert property (@(posedge clk) disable iff (!rstN)
    (running && scClr) |=> tSlot[0]);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (allStrobes == '0 && busSel == 3'd0));

  p_halt_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> !running);

  p_int_entry_r11: assert property (@(posedge clk) disable iff (!rstN)
    (running && tSlot[0] && rFlag) |-> (arClr && trLd && busSel == 3'd2));

  p_read_bus_r12: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busSel == 3'd7);

  p_rd_wr_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
endmodule

bind hc_control_unit hc_control_checker #(.SLOTS(SLOTS)) u_hc_chk (
  .clk(clk), .rstN(rstN), .tSlot(tSlot), .running(running), .scClr(scClr),
  .rFlag(rFlag), .arClr(arClr), .trLd(trLd), .memRd(memRd), .memWr(memWr),
  .busSel(busSel),
  .allStrobes({arLd, arInr, arClr, pcLd, pcInr, pcClr, drLd, drInr,
               acLd, acInr, acClr, irLd, trLd, memRd, memWr})
);

// File: tb/test_hc_control_unit.sv
`timescale 1ns/1ps
module test_hc_control_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] irWord = '0;
  logic eFlag = 0, rFlag = 0, acZero = 0, acSign = 0, drZero = 0, fgi = 0, fgo = 0;
  logic arLd, arInr, arClr, pcLd, pcInr, pcClr, drLd, drInr;
  logic acLd, acInr, acClr, irLd, trLd, memRd, memWr, running;
  logic [2:0] busSel;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hc_control_unit i_hc_control_unit (
    .clk(clk), .rstN(rstN), .irWord(irWord), .eFlag(eFlag), .rFlag(rFlag),
    .acZero(acZero), .acSign(acSign), .drZero(drZero), .fgi(fgi), .fgo(fgo),
    .arLd(arLd), .arInr(arInr), .arClr(arClr), .pcLd(pcLd), .pcInr(pcInr),
    .pcClr(pcClr), .drLd(drLd), .drInr(drInr), .acLd(acLd), .acInr(acInr),
    .acClr(acClr), .irLd(irLd), .trLd(trLd), .memRd(memRd), .memWr(memWr),
    .busSel(busSel), .running(running)
  );

  // observed vector: 15 strobes then the 3-bit bus code
  localparam logic [17:0] AR_LD = 18'h20000, AR_INR = 18'h10000, AR_CLR = 18'h08000;
  localparam logic [17:0] PC_LD = 18'h04000, PC_INR = 18'h02000, PC_CLR = 18'h01000;
  localparam logic [17:0] DR_LD = 18'h00800, DR_INR = 18'h00400, AC_LD = 18'h00200;
  localparam logic [17:0] AC_INR = 18'h00100, AC_CLR = 18'h00080, IR_LD = 18'h00040;
  localparam logic [17:0] TR_LD = 18'h00020, MEM_RD = 18'h00010, MEM_WR = 18'h00008;
  localparam logic [17:0] B_AR = 18'd1, B_PC = 18'd2, B_DR = 18'd3, B_AC = 18'd4;
  localparam logic [17:0] B_IR = 18'd5, B_TR = 18'd6, B_MEM = 18'd7;
  localparam logic [17:0] FETCH0 = AR_LD | B_PC;

  logic [17:0] obs;
  assign obs = {arLd, arInr, arClr, pcLd, pcInr, pcClr, drLd, drInr, acLd,
                acInr, acClr, irLd, trLd, memRd, memWr, busSel};

  task automatic chk(input string req, input logic [17:0] exp);
    #1;
    nChecks++;
    if (obs !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, obs, exp);
    end
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  // R12 checked every cycle while not in reset
  always @(negedge clk) begin
    if (rstN && !done) begin
      nChecks++;
      if ((memRd && busSel != 3'd7) || (memRd && memWr)) begin
        nFail++;
        $display("FAIL R12: rd=%b wr=%b bus=%0d expected bus 7 on read, no rd+wr", memRd, memWr, busSel);
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic fetch(input string req);
    chk(req, FETCH0);
    nextCycle();
    chk(req, IR_LD | PC_INR | MEM_RD | B_MEM);
    nextCycle();
    chk(req, AR_LD | B_IR);
    nextCycle();
  endtask

  // runs one instruction from slot 0; e[k] is the pattern for slot 3+k
  task automatic runOp(input string req, input logic [15:0] ir, input int n,
                       input logic [17:0] e3, input logic [17:0] e4,
                       input logic [17:0] e5, input logic [17:0] e6);
    logic [17:0] e [4];
    e[0] = e3; e[1] = e4; e[2] = e5; e[3] = e6;
    irWord = ir;
    fetch(req);
    for (int k = 0; k < n; k++) begin
      chk(req, e[k]);
      nextCycle();
    end
    chk(req, FETCH0);  // counter back at slot 0
  endtask

  task automatic testReset();
    doReset();
    chk("R1", FETCH0);
  endtask

  task automatic testMemRead();
    runOp("R4", 16'h0123, 3, '0, DR_LD | MEM_RD | B_MEM, AC_LD, '0);
    runOp("R3", 16'h9123, 3, AR_LD | MEM_RD | B_MEM, DR_LD | MEM_RD | B_MEM, AC_LD, '0);
    runOp("R4", 16'h2456, 3, '0, DR_LD | MEM_RD | B_MEM, AC_LD, '0);
  endtask

  task automatic testStaBun();
    runOp("R5", 16'h3010, 2, '0, MEM_WR | B_AC, '0, '0);
    runOp("R5", 16'h4020, 2, '0, PC_LD | B_AR, '0, '0);
  endtask

  task automatic testBsa();
    runOp("R6", 16'h5135, 3, '0, MEM_WR | AR_INR | B_PC, PC_LD | B_AR, '0);
  endtask

  task automatic testIsz();
    drZero = 0;
    runOp("R7", 16'h6040, 4, '0, DR_LD | MEM_RD | B_MEM, DR_INR, MEM_WR | B_DR);
    drZero = 1;
    runOp("R7", 16'h6040, 4, '0, DR_LD | MEM_RD | B_MEM, DR_INR, MEM_WR | PC_INR | B_DR);
    drZero = 0;
  endtask

  task automatic testRegRef();
    runOp("R8", 16'h7800, 1, AC_CLR, '0, '0, '0);
    runOp("R8", 16'h7400, 1, '0, '0, '0, '0);
    runOp("R8", 16'h7200, 1, AC_LD, '0, '0, '0);
    runOp("R8", 16'h7080, 1, AC_LD, '0, '0, '0);
    runOp("R8", 16'h7040, 1, AC_LD, '0, '0, '0);
    runOp("R8", 16'h7020, 1, AC_INR, '0, '0, '0);
    acSign = 0; runOp("R8", 16'h7010, 1, PC_INR, '0, '0, '0);
    acSign = 1; runOp("R8", 16'h7010, 1, '0, '0, '0, '0);
    runOp("R8", 16'h7008, 1, PC_INR, '0, '0, '0);
    acSign = 0; runOp("R8", 16'h7008, 1, '0, '0, '0, '0);
    acZero = 1; runOp("R8", 16'h7004, 1, PC_INR, '0, '0, '0);
    acZero = 0; runOp("R8", 16'h7004, 1, '0, '0, '0, '0);
    eFlag = 0;  runOp("R8", 16'h7002, 1, PC_INR, '0, '0, '0);
    eFlag = 1;  runOp("R8", 16'h7002, 1, '0, '0, '0, '0);
    eFlag = 0;
  endtask

  task automatic testIo();
    runOp("R10", 16'hF800, 1, AC_LD, '0, '0, '0);
    runOp("R10", 16'hF400, 1, B_AC, '0, '0, '0);
    fgi = 1; runOp("R10", 16'hF200, 1, PC_INR, '0, '0, '0);
    fgi = 0; runOp("R10", 16'hF200, 1, '0, '0, '0, '0);
    fgo = 1; runOp("R10", 16'hF100, 1, PC_INR, '0, '0, '0);
    fgo = 0; runOp("R10", 16'hF100, 1, '0, '0, '0, '0);
    runOp("R10", 16'hF080, 1, '0, '0, '0, '0);
  endtask

  task automatic testInterrupt();
    rFlag = 1;
    chk("R11", AR_CLR | TR_LD | B_PC);
    nextCycle();
    chk("R11", MEM_WR | PC_CLR | B_TR);
    nextCycle();
    chk("R11", PC_INR);
    nextCycle();
    rFlag = 0;
    chk("R11", FETCH0);
  endtask

  task automatic testHalt();
    irWord = 16'h7001;
    fetch("R9");
    chk("R9", '0);
    nextCycle();
    for (int k = 0; k < 4; k++) begin
      chk("R9", '0);
      nextCycle();
    end
    irWord = 16'h0000;
    chk("R9", '0);
    doReset();
    chk("R1", FETCH0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testMemRead();
    testStaBun();
    testBsa();
    testIsz();
    testRegRef();
    testIo();
    testInterrupt();
    testHalt();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule